// File: doc/BRIEF.md
# Fast System-Call Entry Unit

This block prepares the processor state for a fast jump into the kernel. Software first programs three model-specific registers: the target code selector, the target stack pointer and the target entry instruction pointer. It does this through a one-cycle register access port. When the instruction decoder pulses an entry request, the unit decides in the same cycle whether the request may proceed. On the next cycle it presents either a complete new ring-0 state with a one-cycle valid pulse, or a one-cycle general-protection fault pulse.

On success, both segment descriptors are fixed flat ring-0 values built inside the unit. No descriptor table is consulted. The stack selector is the code selector plus 8. The stack pointer and the instruction pointer come straight from their registers. The flags word passes through with the virtual-8086 and interrupt-enable flags cleared. Nothing from the caller is saved. On a fault, every state output keeps its previous value.

Top module: `sec_entry_unit`

## Requirements
- R1: The register at access address 0x174 holds the target code selector, 0x175 the target stack pointer and 0x176 the entry instruction pointer. A write with `msr_wr_en` updates the addressed register at the clock edge. A read with `msr_rd_en` presents the value on `msr_rdata`, together with a `msr_rd_valid` pulse, one cycle later.
- R2: A read of any other address returns 0 on `msr_rdata` and sets `msr_rd_bad` with the `msr_rd_valid` pulse. A write to any other address changes no register.
- R3: After reset, all three registers are 0, every state output is 0, and `ent_valid`, `ent_fault` and `msr_rd_valid` are low. An entry request before the code selector has been programmed therefore faults.
- R4: A request with `pe_en` = 0 gives `ent_fault` = 1 one cycle later and leaves all state outputs unchanged.
- R5: A request with `pe_en` = 1 faults when the full 32-bit code-selector register is zero. A nonzero register whose low 16 bits are zero does not fault.
- R6: When both fault conditions hold, exactly one fault pulse is raised, and `ent_fault_pe` = 1 names the protected-mode cause. `ent_fault_pe` = 0 with `ent_fault` names the zero-selector cause.
- R7: A successful request gives a single-cycle `ent_valid` one cycle later. `cs_sel` is the low 16 bits of the code-selector register with bits [1:0] cleared (ring 0), and `ss_sel` = `cs_sel` + 8.
- R8: Descriptors are 58-bit words: [57:26] base, [25:10] limit, [9] G, [8] S, [7:4] type, [3] D, [2:1] DPL, [0] P. On success, `cs_desc` = base 0, limit 0xFFFF, G=1, S=1, type 1011, D=1, DPL=0, P=1. `ss_desc` is the same except type 0011.
- R9: On success, `esp_out` and `eip_out` take the stack-pointer and entry-pointer registers. `eflags_out` is `eflags_in` with bit 17 (VM) and bit 9 (IF) cleared.
- R10: `ent_valid` and `ent_fault` are never high together. A request samples the registers as they were before any write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msr_wr_en | input | 1 | Register write strobe |
| msr_rd_en | input | 1 | Register read strobe |
| msr_addr | input | 32 | Register access address |
| msr_wdata | input | 32 | Write data |
| msr_rdata | output | 32 | Read data, one cycle after the read strobe |
| msr_rd_valid | output | 1 | Read data valid pulse |
| msr_rd_bad | output | 1 | Read hit an unimplemented address |
| pe_en | input | 1 | Protected mode enabled |
| entry_req | input | 1 | Kernel entry request strobe |
| eflags_in | input | 32 | Current flags word |
| ent_valid | output | 1 | New state valid pulse |
| ent_fault | output | 1 | General-protection fault pulse |
| ent_fault_pe | output | 1 | Fault cause: 1 protected mode off, 0 zero selector |
| cs_sel | output | 16 | New code selector |
| ss_sel | output | 16 | New stack selector |
| cs_desc | output | 58 | New code descriptor |
| ss_desc | output | 58 | New stack descriptor |
| esp_out | output | 32 | New stack pointer |
| eip_out | output | 32 | New instruction pointer |
| eflags_out | output | 32 | New flags word |

## Verification
The bench issues a request before any programming, expecting a zero-selector fault. A unit that reset its registers to anything else would instead enter the kernel. It raises both fault conditions at once, expecting one pulse with the protected-mode cause. Inverted priority shows up as a wrong cause bit, and a doubled report shows up as a second pulse. It writes the code selector in the same cycle as a request, expecting the old value, which a write-through path would violate. It also uses a selector register that is nonzero only above bit 15 and one with nonzero privilege bits, which exposes a zero check done on the truncated selector and missing ring-0 masking.

// File: rtl/sec_pkg.sv
package sec_pkg;

    localparam int unsigned MSR_AW  = 32;
    localparam int unsigned MSR_DW  = 32;
    localparam int unsigned SEL_W   = 16;
    localparam int unsigned N_MSR   = 3;
    localparam int unsigned IDX_W   = $clog2(N_MSR);
    localparam logic [MSR_AW-1:0] MSR_BASE = 32'h0000_0174;

    localparam int unsigned IDX_CS  = 0;
    localparam int unsigned IDX_ESP = 1;
    localparam int unsigned IDX_EIP = 2;

    localparam int unsigned FLAG_VM_BIT = 17;
    localparam int unsigned FLAG_IF_BIT = 9;

    localparam logic [SEL_W-1:0] SS_OFFSET = 16'd8;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] limit;
        logic        gran;
        logic        sys_n;
        logic [3:0]  kind;
        logic        dbig;
        logic [1:0]  dpl;
        logic        present;
    } seg_desc_t;

    localparam int unsigned DESC_W = $bits(seg_desc_t);

    localparam logic [3:0] KIND_CODE  = 4'b1011;
    localparam logic [3:0] KIND_STACK = 4'b0011;

    function automatic seg_desc_t flat_ring0(input logic [3:0] kind);
        seg_desc_t d;
        d.base    = '0;
        d.limit   = 16'hFFFF;
        d.gran    = 1'b1;
        d.sys_n   = 1'b1;
        d.kind    = kind;
        d.dbig    = 1'b1;
        d.dpl     = 2'b00;
        d.present = 1'b1;
        return d;
    endfunction

    function automatic logic [SEL_W-1:0] ring0_sel(input logic [SEL_W-1:0] s);
        return {s[SEL_W-1:2], 2'b00};
    endfunction

    function automatic logic [31:0] entry_flags(input logic [31:0] f);
        logic [31:0] r;
        r = f;
        r[FLAG_VM_BIT] = 1'b0;
        r[FLAG_IF_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sec_msr_bank.sv
module sec_msr_bank
    import sec_pkg::*;
#(
    parameter int unsigned AW = MSR_AW,
    parameter int unsigned DW = MSR_DW,
    parameter int unsigned NR = N_MSR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rd_valid,
    output logic          rd_bad,
    output logic [DW-1:0] cs_q,
    output logic [DW-1:0] esp_q,
    output logic [DW-1:0] eip_q
);

    logic [NR-1:0][DW-1:0] regs_q;
    logic [NR-1:0]         hit;
    logic [DW-1:0]         rd_mux;

    for (genvar i = 0; i < NR; i++) begin : g_dec
        assign hit[i] = (addr == (MSR_BASE + AW'(i)));
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NR; i++) begin
            if (hit[i]) rd_mux = regs_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NR; i++) begin
                if (hit[i]) regs_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
            rd_bad   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rdata  <= rd_mux;
                rd_bad <= ~|hit;
            end else begin
                rd_bad <= 1'b0;
            end
        end
    end

    assign cs_q  = regs_q[IDX_CS];
    assign esp_q = regs_q[IDX_ESP];
    assign eip_q = regs_q[IDX_EIP];

endmodule

// File: rtl/sec_guard.sv
module sec_guard
    import sec_pkg::*;
#(
    parameter int unsigned DW = MSR_DW
) (
    input  logic          req,
    input  logic          pe_en,
    input  logic [DW-1:0] cs_val,
    output logic          go,
    output logic          fault,
    output logic          fault_pe
);

    logic sel_null;

    always_comb begin
        sel_null = (cs_val == '0);
        fault_pe = req && !pe_en;
        fault    = req && (!pe_en || sel_null);
        go       = req && pe_en && !sel_null;
    end

endmodule

// File: rtl/sec_state_build.sv
module sec_state_build
    import sec_pkg::*;
#(
    parameter int unsigned DW = MSR_DW,
    parameter int unsigned SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          fault,
    input  logic          fault_pe,
    input  logic [DW-1:0] cs_val,
    input  logic [DW-1:0] esp_val,
    input  logic [DW-1:0] eip_val,
    input  logic [31:0]   eflags_in,
    output logic          valid_o,
    output logic          fault_o,
    output logic          fault_pe_o,
    output logic [SW-1:0] cs_sel_o,
    output logic [SW-1:0] ss_sel_o,
    output seg_desc_t     cs_desc_o,
    output seg_desc_t     ss_desc_o,
    output logic [DW-1:0] esp_o,
    output logic [DW-1:0] eip_o,
    output logic [31:0]   eflags_o
);

    logic [SW-1:0] sel_r0;

    assign sel_r0 = ring0_sel(cs_val[SW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o    <= 1'b0;
            fault_o    <= 1'b0;
            fault_pe_o <= 1'b0;
            cs_sel_o   <= '0;
            ss_sel_o   <= '0;
            cs_desc_o  <= '0;
            ss_desc_o  <= '0;
            esp_o      <= '0;
            eip_o      <= '0;
            eflags_o   <= '0;
        end else begin
            valid_o    <= go;
            fault_o    <= fault;
            fault_pe_o <= fault && fault_pe;
            if (go) begin
                cs_sel_o  <= sel_r0;
                ss_sel_o  <= sel_r0 + SS_OFFSET;
                cs_desc_o <= flat_ring0(KIND_CODE);
                ss_desc_o <= flat_ring0(KIND_STACK);
                esp_o     <= esp_val;
                eip_o     <= eip_val;
                eflags_o  <= entry_flags(eflags_in);
            end
        end
    end

endmodule

// File: rtl/sec_entry_unit.sv
module sec_entry_unit
    import sec_pkg::*;
#(
    parameter int unsigned AW = MSR_AW,
    parameter int unsigned DW = MSR_DW,
    parameter int unsigned SW = SEL_W,
    localparam int unsigned DSW = DESC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           msr_wr_en,
    input  logic           msr_rd_en,
    input  logic [AW-1:0]  msr_addr,
    input  logic [DW-1:0]  msr_wdata,
    output logic [DW-1:0]  msr_rdata,
    output logic           msr_rd_valid,
    output logic           msr_rd_bad,
    input  logic           pe_en,
    input  logic           entry_req,
    input  logic [31:0]    eflags_in,
    output logic           ent_valid,
    output logic           ent_fault,
    output logic           ent_fault_pe,
    output logic [SW-1:0]  cs_sel,
    output logic [SW-1:0]  ss_sel,
    output logic [DSW-1:0] cs_desc,
    output logic [DSW-1:0] ss_desc,
    output logic [DW-1:0]  esp_out,
    output logic [DW-1:0]  eip_out,
    output logic [31:0]    eflags_out
);

    logic [DW-1:0] cs_q, esp_q, eip_q;
    logic          go, fault, fault_pe;
    seg_desc_t     cs_d, ss_d;

    sec_msr_bank #(.AW(AW), .DW(DW), .NR(N_MSR)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (msr_wr_en),
        .rd_en    (msr_rd_en),
        .addr     (msr_addr),
        .wdata    (msr_wdata),
        .rdata    (msr_rdata),
        .rd_valid (msr_rd_valid),
        .rd_bad   (msr_rd_bad),
        .cs_q     (cs_q),
        .esp_q    (esp_q),
        .eip_q    (eip_q)
    );

    sec_guard #(.DW(DW)) u_guard (
        .req      (entry_req),
        .pe_en    (pe_en),
        .cs_val   (cs_q),
        .go       (go),
        .fault    (fault),
        .fault_pe (fault_pe)
    );

    sec_state_build #(.DW(DW), .SW(SW)) u_build (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .fault      (fault),
        .fault_pe   (fault_pe),
        .cs_val     (cs_q),
        .esp_val    (esp_q),
        .eip_val    (eip_q),
        .eflags_in  (eflags_in),
        .valid_o    (ent_valid),
        .fault_o    (ent_fault),
        .fault_pe_o (ent_fault_pe),
        .cs_sel_o   (cs_sel),
        .ss_sel_o   (ss_sel),
        .cs_desc_o  (cs_d),
        .ss_desc_o  (ss_d),
        .esp_o      (esp_out),
        .eip_o      (eip_out),
        .eflags_o   (eflags_out)
    );

    assign cs_desc = cs_d;
    assign ss_desc = ss_d;

endmodule

// File: rtl/sec_entry_chk.sv
module sec_entry_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          pe_en,
    input logic          entry_req,
    input logic          msr_rd_bad,
    input logic [DW-1:0] msr_rdata,
    input logic          ent_valid,
    input logic          ent_fault,
    input logic          ent_fault_pe,
    input logic [SW-1:0] cs_sel,
    input logic [SW-1:0] ss_sel,
    input logic [DW-1:0] esp_out,
    input logic [DW-1:0] eip_out,
    input logic [31:0]   eflags_out
);

    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(ent_valid && ent_fault));

    assert_pe_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (entry_req && !pe_en) |=> (ent_fault && ent_fault_pe));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ent_fault |-> ($stable(cs_sel) && $stable(esp_out) && $stable(eip_out)));

    assert_cause_R6: assert property (@(posedge clk) disable iff (rst)
        ent_fault_pe |-> ent_fault);

    assert_ss_R7: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (ss_sel == cs_sel + 16'd8 && cs_sel[1:0] == 2'b00));

    assert_no_req_R7: assert property (@(posedge clk) disable iff (rst)
        !entry_req |=> (!ent_valid && !ent_fault));

    assert_flags_R9: assert property (@(posedge clk) disable iff (rst)
        ent_valid |-> (!eflags_out[17] && !eflags_out[9]));

    assert_bad_R2: assert property (@(posedge clk) disable iff (rst)
        msr_rd_bad |-> (msr_rdata == '0));

endmodule

bind sec_entry_unit sec_entry_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pe_en        (pe_en),
    .entry_req    (entry_req),
    .msr_rd_bad   (msr_rd_bad),
    .msr_rdata    (msr_rdata),
    .ent_valid    (ent_valid),
    .ent_fault    (ent_fault),
    .ent_fault_pe (ent_fault_pe),
    .cs_sel       (cs_sel),
    .ss_sel       (ss_sel),
    .esp_out      (esp_out),
    .eip_out      (eip_out),
    .eflags_out   (eflags_out)
);

// File: tb/sec_entry_unit_tb_top.sv
`timescale 1ns/1ps
module sec_entry_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        msr_wr_en, msr_rd_en;
    logic [31:0] msr_addr, msr_wdata, msr_rdata;
    logic        msr_rd_valid, msr_rd_bad;
    logic        pe_en, entry_req;
    logic [31:0] eflags_in;
    logic        ent_valid, ent_fault, ent_fault_pe;
    logic [15:0] cs_sel, ss_sel;
    logic [57:0] cs_desc, ss_desc;
    logic [31:0] esp_out, eip_out, eflags_out;

    int checks = 0;
    int fails  = 0;

    localparam logic [57:0] EXP_CS_DESC = {32'h0, 16'hFFFF, 1'b1, 1'b1, 4'b1011, 1'b1, 2'b00, 1'b1};
    localparam logic [57:0] EXP_SS_DESC = {32'h0, 16'hFFFF, 1'b1, 1'b1, 4'b0011, 1'b1, 2'b00, 1'b1};

    always #2.5 clk = ~clk;

    sec_entry_unit dut_i (
        .clk(clk), .rst(rst),
        .msr_wr_en(msr_wr_en), .msr_rd_en(msr_rd_en), .msr_addr(msr_addr),
        .msr_wdata(msr_wdata), .msr_rdata(msr_rdata), .msr_rd_valid(msr_rd_valid),
        .msr_rd_bad(msr_rd_bad), .pe_en(pe_en), .entry_req(entry_req),
        .eflags_in(eflags_in), .ent_valid(ent_valid), .ent_fault(ent_fault),
        .ent_fault_pe(ent_fault_pe), .cs_sel(cs_sel), .ss_sel(ss_sel),
        .cs_desc(cs_desc), .ss_desc(ss_desc), .esp_out(esp_out),
        .eip_out(eip_out), .eflags_out(eflags_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic msr_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        msr_wr_en = 1'b1; msr_addr = a; msr_wdata = d;
        @(negedge clk);
        msr_wr_en = 1'b0;
    endtask

    task automatic msr_read(input logic [31:0] a, output logic [31:0] d, output logic bad, output logic vld);
        @(negedge clk);
        msr_rd_en = 1'b1; msr_addr = a;
        @(negedge clk);
        msr_rd_en = 1'b0;
        d = msr_rdata; bad = msr_rd_bad; vld = msr_rd_valid;
    endtask

    // Issue one request; outputs sampled at the negedge after the capturing edge.
    task automatic entry(input logic pe, input logic [31:0] efl);
        @(negedge clk);
        entry_req = 1'b1; pe_en = pe; eflags_in = efl;
        @(negedge clk);
        entry_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic b, v;
        chk_eq("R3 valid low", {63'b0, ent_valid}, 64'd0);
        chk_eq("R3 fault low", {63'b0, ent_fault}, 64'd0);
        chk_eq("R3 cs_sel zero", {48'b0, cs_sel}, 64'd0);
        chk_eq("R3 esp zero", {32'b0, esp_out}, 64'd0);
        chk_eq("R3 desc zero", {6'b0, cs_desc}, 64'd0);
        msr_read(32'h174, d, b, v);
        chk_eq("R3 cs msr zero", {32'b0, d}, 64'd0);
        chk_eq("R1 rd_valid", {63'b0, v}, 64'd1);
    endtask

    task automatic t_unprogrammed;
        entry(1'b1, 32'h0000_0202);
        chk_eq("R5 zero selector fault", {62'b0, ent_fault, ent_valid}, 64'd2);
        chk_eq("R6 cause zero-selector", {63'b0, ent_fault_pe}, 64'd0);
        chk_eq("R3 state kept", {32'b0, eip_out}, 64'd0);
    endtask

    task automatic t_both_faults;
        entry(1'b0, 32'h0);
        chk_eq("R6 single fault", {62'b0, ent_fault, ent_valid}, 64'd2);
        chk_eq("R6 cause protected-mode", {63'b0, ent_fault_pe}, 64'd1);
        @(negedge clk);
        chk_eq("R6 one pulse only", {63'b0, ent_fault}, 64'd0);
    endtask

    task automatic t_program;
        logic [31:0] d; logic b, v;
        msr_write(32'h174, 32'h0000_0013);
        msr_write(32'h175, 32'hC0DE_1000);
        msr_write(32'h176, 32'h8000_4000);
        msr_read(32'h174, d, b, v);
        chk_eq("R1 cs readback", {32'b0, d}, 64'h13);
        chk_eq("R1 good read not bad", {63'b0, b}, 64'd0);
        msr_read(32'h175, d, b, v);
        chk_eq("R1 esp readback", {32'b0, d}, 64'hC0DE_1000);
        msr_read(32'h176, d, b, v);
        chk_eq("R1 eip readback", {32'b0, d}, 64'h8000_4000);
    endtask

    task automatic t_bad_addr;
        logic [31:0] d; logic b, v;
        msr_read(32'h177, d, b, v);
        chk_eq("R2 bad read data", {32'b0, d}, 64'd0);
        chk_eq("R2 bad flag", {62'b0, b, v}, 64'd3);
        msr_read(32'h173, d, b, v);
        chk_eq("R2 bad flag low side", {63'b0, b}, 64'd1);
        msr_write(32'h0000_0177, 32'hFFFF_FFFF);
        msr_write(32'h0001_0174, 32'hFFFF_FFFF);
        msr_read(32'h174, d, b, v);
        chk_eq("R2 stray write ignored cs", {32'b0, d}, 64'h13);
        msr_read(32'h176, d, b, v);
        chk_eq("R2 stray write ignored eip", {32'b0, d}, 64'h8000_4000);
    endtask

    task automatic t_success;
        entry(1'b1, 32'hFFFF_FFFF);
        chk_eq("R7 valid pulse", {62'b0, ent_valid, ent_fault}, 64'd2);
        chk_eq("R7 cs ring0", {48'b0, cs_sel}, 64'h10);
        chk_eq("R7 ss plus 8", {48'b0, ss_sel}, 64'h18);
        chk_eq("R8 code desc", {6'b0, cs_desc}, {6'b0, EXP_CS_DESC});
        chk_eq("R8 stack desc", {6'b0, ss_desc}, {6'b0, EXP_SS_DESC});
        chk_eq("R9 esp", {32'b0, esp_out}, 64'hC0DE_1000);
        chk_eq("R9 eip", {32'b0, eip_out}, 64'h8000_4000);
        chk_eq("R9 flags", {32'b0, eflags_out}, 64'hFFFD_FDFF);
        @(negedge clk);
        chk_eq("R7 single valid", {63'b0, ent_valid}, 64'd0);
    endtask

    task automatic t_pe_off_keeps;
        msr_write(32'h175, 32'h1111_2222);
        entry(1'b0, 32'h0);
        chk_eq("R4 fault pe", {61'b0, ent_fault, ent_fault_pe, ent_valid}, 64'd6);
        chk_eq("R4 esp unchanged", {32'b0, esp_out}, 64'hC0DE_1000);
        chk_eq("R4 flags unchanged", {32'b0, eflags_out}, 64'hFFFD_FDFF);
    endtask

    task automatic t_same_cycle_write;
        @(negedge clk);
        entry_req = 1'b1; pe_en = 1'b1; eflags_in = 32'h0002_0000;
        msr_wr_en = 1'b1; msr_addr = 32'h174; msr_wdata = 32'h0000_0040;
        @(negedge clk);
        entry_req = 1'b0; msr_wr_en = 1'b0;
        chk_eq("R10 old selector used", {48'b0, cs_sel}, 64'h10);
        chk_eq("R10 valid only", {62'b0, ent_valid, ent_fault}, 64'd2);
        entry(1'b1, 32'h0002_0000);
        chk_eq("R7 new selector", {48'b0, cs_sel}, 64'h40);
        chk_eq("R7 new ss", {48'b0, ss_sel}, 64'h48);
        chk_eq("R9 vm cleared", {32'b0, eflags_out}, 64'd0);
        chk_eq("R9 esp reload", {32'b0, esp_out}, 64'h1111_2222);
    endtask

    task automatic t_high_bits_selector;
        msr_write(32'h174, 32'h0001_0000);
        entry(1'b1, 32'h0000_0001);
        chk_eq("R5 high bits no fault", {62'b0, ent_valid, ent_fault}, 64'd2);
        chk_eq("R5 cs truncated", {48'b0, cs_sel}, 64'h0);
        chk_eq("R7 ss from zero", {48'b0, ss_sel}, 64'h8);
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; msr_wr_en = 1'b0; msr_rd_en = 1'b0; msr_addr = '0; msr_wdata = '0;
        pe_en = 1'b0; entry_req = 1'b0; eflags_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_unprogrammed;
        t_both_faults;
        t_program;
        t_bad_addr;
        t_success;
        t_pe_off_keeps;
        t_same_cycle_write;
        t_high_bits_selector;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule